// File: doc/BRIEF.md
# Small Loop Replay Buffer

This block sits between decode and dispatch. In normal operation it forwards the decoded instruction stream one instruction per cycle. When a taken backward branch closes a short loop, it records the next trip through the body into a small array of decoded entries. From the trip after that it sends the loop to dispatch out of its own storage, three instructions per cycle. While it does so it raises a gate that switches off fetch and most of decode.

Program counters count instructions, so sequential instructions differ by one. The recorded path follows any taken forward branch inside the body, and replay skips the same entries. Loop mode ends at once on a flush or a mispredict, and the array is cleared. A mispredict that ends replay also sends fetch back to the instruction just after the loop-closing branch. Upstream must hold or drop its pending instruction while the gate is high, because `in_ready` stays low for the whole of replay.

Both streams use valid/ready. An input instruction moves on a cycle with `in_valid` and `in_ready` high. An output group moves on a cycle with `out_ready` high, and every lane marked in `out_valid` moves together. Lane contents must not change while any lane is valid and `out_ready` is low.

Top module: `lbuf_replay`

## Requirements
- R1: A taken backward branch whose target lies at most DEPTH-1 below its own pc starts capture. A body of DEPTH+1 or more instructions never reaches replay.
- R2: The cycle after the closing taken backward branch (pc = start+L-1, target = start) of the capture pass is accepted, `fe_gate` is high and `in_ready` is low.
- R3: While replaying with no flush or mispredict, all three lanes are valid. Lane k carries the pc and op of the k-th next entry on the recorded path, and the path wraps from the closing branch back to the start.
- R4: A forward branch that was taken during capture makes replay continue at its recorded target, skipping the entries in between.
- R5: A capture pass may hold up to two forward branches, taken or not. A third forward branch aborts capture, and no replay follows.
- R6: A backward branch during capture that is not the expected closing branch aborts capture, and no replay follows.
- R7: A mispredict during replay with no flush drops `fe_gate` in the next cycle and raises `fe_restart` for one cycle, with `fe_restart_pc` = start+L.
- R8: A flush drops `fe_gate` in the next cycle with no `fe_restart` pulse. A flush or mispredict in the same cycle as the closing branch prevents replay.
- R9: Outside replay, lane 0 carries the input instruction, `out_valid` is 3'b001 when `in_valid` is high, and `in_ready` equals `out_ready`.
- R10: During replay with `out_ready` low, the lane contents stay unchanged and the sequence resumes without loss once `out_ready` rises.
- R11: After reset `fe_gate`, `fe_restart` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_pc | input | PCW | Instruction pc, in instruction units |
| in_op | input | OPW | Decoded payload |
| in_is_br | input | 1 | Instruction is a branch |
| in_fwd | input | 1 | Branch goes forward (1) or backward (0) |
| in_taken | input | 1 | Branch predicted or resolved taken |
| in_tgt | input | PCW | Branch target pc |
| flush | input | 1 | Exception flush |
| mispredict | input | 1 | Branch mispredict |
| out_valid | output | LANES | Per-lane valid |
| out_ready | input | 1 | Dispatch takes all valid lanes |
| out_pc | output | LANES*PCW | Lane pcs, lane k at bits k*PCW |
| out_op | output | LANES*OPW | Lane payloads, lane k at bits k*OPW |
| fe_gate | output | 1 | Fetch and decode gated off |
| fe_restart | output | 1 | One-cycle fetch restart request |
| fe_restart_pc | output | PCW | Restart pc |

## Verification
Two events can land in the same cycle. A kill (flush or mispredict) can arrive together with the closing branch that would otherwise start replay. It can also arrive while replay lanes are being handed to dispatch. The bench drives a mispredict on the exact cycle of the closing branch and expects no gate and no restart. It also drives a flush during replay and expects the gate to drop with no restart. In both cases the killed cycle's lanes must not be taken as progress.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_RPLY = 2'd2
  } lb_state_e;
endpackage

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int DEPTH = 32,
  parameter int OPW   = 16,
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [OPW-1:0]         wop,
  input  logic                   wtk,
  input  logic [$clog2(DEPTH)-1:0] wtgt,
  input  logic [LANES*$clog2(DEPTH)-1:0] ridx,
  output logic [LANES*OPW-1:0]   rop,
  output logic [LANES-1:0]       rvld,
  output logic [DEPTH-1:0]       tk_vec,
  output logic [DEPTH*$clog2(DEPTH)-1:0] tgt_vec
);
  localparam int IW = $clog2(DEPTH);

  logic [OPW-1:0]   op_m  [DEPTH];
  logic [IW-1:0]    tgt_m [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] tk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tk_q  <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (we) begin
      vld_q[widx] <= 1'b1;
      tk_q[widx]  <= wtk;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !clr) begin
      op_m[widx]  <= wop;
      tgt_m[widx] <= wtgt;
    end
  end

  assign tk_vec = tk_q;

  for (genvar d = 0; d < DEPTH; d++) begin : g_tgt
    assign tgt_vec[d*IW +: IW] = tgt_m[d];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rop[g*OPW +: OPW] = op_m[ridx[g*IW +: IW]];
    assign rvld[g]           = vld_q[ridx[g*IW +: IW]];
  end
endmodule

// File: rtl/lbuf_seq.sv
module lbuf_seq #(
  parameter int DEPTH = 32,
  parameter int LANES = 3
) (
  input  logic [$clog2(DEPTH)-1:0]       ptr,
  input  logic [$clog2(DEPTH)-1:0]       last,
  input  logic [DEPTH-1:0]               tk_vec,
  input  logic [DEPTH*$clog2(DEPTH)-1:0] tgt_vec,
  output logic [LANES*$clog2(DEPTH)-1:0] lidx,
  output logic [$clog2(DEPTH)-1:0]       nptr
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] chain [LANES+1];

  always_comb begin
    chain[0] = ptr;
    for (int g = 0; g < LANES; g++) begin
      if (chain[g] == last)
        chain[g+1] = '0;
      else if (tk_vec[chain[g]])
        chain[g+1] = tgt_vec[32'(chain[g])*IW +: IW];
      else
        chain[g+1] = chain[g] + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lidx[g*IW +: IW] = chain[g];
  end
  assign nptr = chain[LANES];
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PCW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_fire,
  input  logic [PCW-1:0]           in_pc,
  input  logic                     in_is_br,
  input  logic                     in_fwd,
  input  logic                     in_taken,
  input  logic [PCW-1:0]           in_tgt,
  input  logic                     flush,
  input  logic                     mispredict,
  input  logic                     out_fire,
  input  logic [$clog2(DEPTH)-1:0] nptr,
  output lb_state_e                state_q,
  output logic [PCW-1:0]           start_q,
  output logic [$clog2(DEPTH)-1:0] last_q,
  output logic [$clog2(DEPTH)-1:0] ptr_q,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] widx,
  output logic                     wtk,
  output logic [$clog2(DEPTH)-1:0] wtgt,
  output logic                     clr,
  output logic                     restart_q,
  output logic [PCW-1:0]           restart_pc_q
);
  localparam int IW = $clog2(DEPTH);

  lb_state_e      st_d;
  logic [PCW-1:0] start_d, span, tgt_off;
  logic [IW-1:0]  last_d, exp_q, exp_d, ptr_d;
  logic [1:0]     fcnt_q, fcnt_d;
  logic           kill, match, at_end, abort;

  assign kill    = flush | mispredict;
  assign span    = in_pc - in_tgt;
  assign tgt_off = in_tgt - start_q;
  assign match   = (in_pc == start_q + PCW'(exp_q));
  assign at_end  = (exp_q == last_q);
  assign widx    = exp_q;
  assign wtk     = in_is_br & in_fwd & in_taken;
  assign wtgt    = tgt_off[IW-1:0];

  always_comb begin
    st_d    = state_q;
    start_d = start_q;
    last_d  = last_q;
    exp_d   = exp_q;
    fcnt_d  = fcnt_q;
    ptr_d   = ptr_q;
    clr     = 1'b0;
    we      = 1'b0;
    abort   = 1'b0;
    if (kill) begin
      abort = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (in_fire && in_is_br && !in_fwd && in_taken &&
              in_tgt <= in_pc && span < PCW'(DEPTH)) begin
            st_d    = ST_CAPT;
            start_d = in_tgt;
            last_d  = span[IW-1:0];
            exp_d   = '0;
            fcnt_d  = '0;
            clr     = 1'b1;
          end
        end
        ST_CAPT: begin
          if (in_fire) begin
            we = match;
            if (!match) begin
              abort = 1'b1;
            end else if (in_is_br && !in_fwd) begin
              if (at_end && in_taken && in_tgt == start_q) begin
                st_d  = ST_RPLY;
                ptr_d = '0;
              end else begin
                abort = 1'b1;
              end
            end else if (at_end) begin
              abort = 1'b1;
            end else if (in_is_br) begin
              if (fcnt_q == 2'd2) begin
                abort = 1'b1;
              end else begin
                fcnt_d = fcnt_q + 2'd1;
                if (!in_taken)
                  exp_d = exp_q + 1'b1;
                else if (in_tgt > in_pc && tgt_off <= PCW'(last_q))
                  exp_d = tgt_off[IW-1:0];
                else
                  abort = 1'b1;
              end
            end else begin
              exp_d = exp_q + 1'b1;
            end
          end
        end
        ST_RPLY: if (out_fire) ptr_d = nptr;
        default: abort = 1'b1;
      endcase
    end
    if (abort) begin
      st_d = ST_IDLE;
      clr  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      start_q      <= '0;
      last_q       <= '0;
      exp_q        <= '0;
      fcnt_q       <= '0;
      ptr_q        <= '0;
      restart_q    <= 1'b0;
      restart_pc_q <= '0;
    end else begin
      state_q      <= st_d;
      start_q      <= start_d;
      last_q       <= last_d;
      exp_q        <= exp_d;
      fcnt_q       <= fcnt_d;
      ptr_q        <= ptr_d;
      restart_q    <= (state_q == ST_RPLY) && mispredict && !flush;
      restart_pc_q <= start_q + PCW'(last_q) + PCW'(1);
    end
  end

  AST_THIRD_FWD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPT && in_fire && in_is_br && in_fwd && fcnt_q == 2'd2)
    |=> (state_q == ST_IDLE)); // R5

  AST_REPLAY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RPLY && $past(state_q) == ST_CAPT)
    |-> $past(in_fire && in_is_br && !in_fwd && in_taken && !kill)); // R2
endmodule

// File: rtl/lbuf_replay.sv
module lbuf_replay
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PCW   = 16,
  parameter int OPW   = 16,
  parameter int LANES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PCW-1:0]       in_pc,
  input  logic [OPW-1:0]       in_op,
  input  logic                 in_is_br,
  input  logic                 in_fwd,
  input  logic                 in_taken,
  input  logic [PCW-1:0]       in_tgt,
  input  logic                 flush,
  input  logic                 mispredict,
  output logic [LANES-1:0]     out_valid,
  input  logic                 out_ready,
  output logic [LANES*PCW-1:0] out_pc,
  output logic [LANES*OPW-1:0] out_op,
  output logic                 fe_gate,
  output logic                 fe_restart,
  output logic [PCW-1:0]       fe_restart_pc
);
  localparam int IW = $clog2(DEPTH);

  lb_state_e              state;
  logic [PCW-1:0]         start;
  logic [IW-1:0]          last, ptr, nptr, widx, wtgt;
  logic                   we, wtk, clr, kill, in_fire, out_fire;
  logic [LANES*IW-1:0]    lidx;
  logic [LANES*OPW-1:0]   rop;
  logic [LANES-1:0]       rvld;
  logic [DEPTH-1:0]       tk_vec;
  logic [DEPTH*IW-1:0]    tgt_vec;

  assign kill     = flush | mispredict;
  assign fe_gate  = (state == ST_RPLY);
  assign in_ready = out_ready & ~fe_gate;
  assign in_fire  = in_valid & in_ready;
  assign out_fire = fe_gate & out_ready & ~kill;

  lbuf_ctrl #(.DEPTH(DEPTH), .PCW(PCW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_pc(in_pc),
    .in_is_br(in_is_br), .in_fwd(in_fwd), .in_taken(in_taken), .in_tgt(in_tgt),
    .flush(flush), .mispredict(mispredict), .out_fire(out_fire), .nptr(nptr),
    .state_q(state), .start_q(start), .last_q(last), .ptr_q(ptr),
    .we(we), .widx(widx), .wtk(wtk), .wtgt(wtgt), .clr(clr),
    .restart_q(fe_restart), .restart_pc_q(fe_restart_pc)
  );

  lbuf_store #(.DEPTH(DEPTH), .OPW(OPW), .LANES(LANES)) store_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .we(we), .widx(widx), .wop(in_op),
    .wtk(wtk), .wtgt(wtgt), .ridx(lidx), .rop(rop), .rvld(rvld),
    .tk_vec(tk_vec), .tgt_vec(tgt_vec)
  );

  lbuf_seq #(.DEPTH(DEPTH), .LANES(LANES)) seq_i (
    .ptr(ptr), .last(last), .tk_vec(tk_vec), .tgt_vec(tgt_vec),
    .lidx(lidx), .nptr(nptr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    always_comb begin
      if (fe_gate) begin
        out_valid[g]         = rvld[g] & ~kill;
        out_pc[g*PCW +: PCW] = start + PCW'(lidx[g*IW +: IW]);
        out_op[g*OPW +: OPW] = rop[g*OPW +: OPW];
      end else if (g == 0) begin
        out_valid[g]         = in_valid;
        out_pc[g*PCW +: PCW] = in_pc;
        out_op[g*OPW +: OPW] = in_op;
      end else begin
        out_valid[g]         = 1'b0;
        out_pc[g*PCW +: PCW] = '0;
        out_op[g*OPW +: OPW] = '0;
      end
    end
  end

  AST_LANES_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_gate && !kill) |-> (&out_valid)); // R3

  AST_MISPRED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_gate && mispredict && !flush) |=> (fe_restart && !fe_gate)); // R7

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!fe_restart && !fe_gate)); // R8

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_gate && $past(fe_gate && !kill && !out_ready)) |-> $stable(out_pc)); // R10
endmodule

// File: tb/lbuf_replay_tb.sv
`timescale 1ns/1ps
module lbuf_replay_tb_top;
  localparam int DEPTH = 8;
  localparam int PCW   = 16;
  localparam int OPW   = 16;
  localparam int LANES = 3;
  localparam logic [PCW-1:0] BASE = 16'd40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_is_br = 0, in_fwd = 0, in_taken = 0;
  logic flush = 0, mispredict = 0, out_ready = 1;
  logic [PCW-1:0] in_pc = '0, in_tgt = '0;
  logic [OPW-1:0] in_op = '0;
  logic in_ready, fe_gate, fe_restart;
  logic [LANES-1:0] out_valid;
  logic [LANES*PCW-1:0] out_pc;
  logic [LANES*OPW-1:0] out_op;
  logic [PCW-1:0] fe_restart_pc;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lbuf_replay #(.DEPTH(DEPTH), .PCW(PCW), .OPW(OPW), .LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_op(in_op), .in_is_br(in_is_br), .in_fwd(in_fwd),
    .in_taken(in_taken), .in_tgt(in_tgt), .flush(flush), .mispredict(mispredict),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_op(out_op),
    .fe_gate(fe_gate), .fe_restart(fe_restart), .fe_restart_pc(fe_restart_pc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [OPW-1:0] op_of(input logic [PCW-1:0] pc);
    return pc ^ 16'h5A5A;
  endfunction

  // drive one instruction at a negedge; the posedge after accepts it
  task automatic send(input logic [PCW-1:0] pc, input bit br, input bit fwd,
                      input bit tk, input logic [PCW-1:0] tgt);
    @(negedge clk);
    in_valid = 1; in_pc = pc; in_op = op_of(pc);
    in_is_br = br; in_fwd = fwd; in_taken = tk; in_tgt = tgt;
    #0.5;
    chk(out_valid == 3'b001, "R9 lanes", out_valid, 1);
    chk(out_pc[PCW-1:0] == pc && out_op[OPW-1:0] == op_of(pc), "R9 pass", out_pc[PCW-1:0], pc);
    chk(in_ready == 1'b1, "R9 ready", in_ready, 1);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_is_br = 0; in_fwd = 0; in_taken = 0;
    #0.5;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    #0.5;
    chk(!fe_gate && !fe_restart, "R8 flush", {fe_gate, fe_restart}, 0);
  endtask

  // one trigger branch, then a capture pass; bit p of mask: taken forward branch at p jumping to p+2
  task automatic capture(input int L, input int mask, input bit stray_bwd,
                         output int path[32], output int plen, output int nf);
    int i;
    plen = 0; nf = 0; i = 0;
    send(BASE + PCW'(L - 1), 1, 0, 1, BASE);
    while (1) begin
      path[plen] = i; plen++;
      if (i == L - 1) begin
        send(BASE + PCW'(i), 1, 0, 1, BASE);
        break;
      end else if (stray_bwd && i == 1) begin
        send(BASE + PCW'(i), 1, 0, 1, BASE);
        i++;
      end else if (mask[i]) begin
        nf++;
        send(BASE + PCW'(i), 1, 1, 1, BASE + PCW'(i + 2));
        i += 2;
      end else begin
        send(BASE + PCW'(i), 0, 0, 0, '0);
        i++;
      end
    end
  endtask

  task automatic check_lanes(input int path[32], input int plen, input int n, input string req);
    for (int k = 0; k < LANES; k++) begin
      logic [PCW-1:0] ep;
      ep = BASE + PCW'(path[(n + k) % plen]);
      chk(out_valid[k], req, out_valid[k], 1);
      chk(out_pc[k*PCW +: PCW] == ep && out_op[k*OPW +: OPW] == op_of(ep),
          req, out_pc[k*PCW +: PCW], ep);
    end
  endtask

  task automatic run_case(input int L, input int mask);
    int path[32]; int plen; int nf; int n; bit ok;
    capture(L, mask, 0, path, plen, nf);
    idle();
    ok = (L <= DEPTH) && (nf <= 2);
    chk(fe_gate == ok, ok ? "R2 gate" : (L > DEPTH ? "R1 length" : "R5 third fwd"), fe_gate, ok);
    if (ok) begin
      chk(in_ready == 1'b0, "R2 ready", in_ready, 0);
      n = 0;
      for (int c = 0; c < 3; c++) begin
        check_lanes(path, plen, n, (nf != 0) ? "R4 skip" : "R3 lanes");
        @(negedge clk); #0.5;
        n += LANES;
      end
      mispredict = 1;
      @(negedge clk); mispredict = 0; #0.5;
      chk(fe_restart && !fe_gate, "R7 restart", {fe_restart, fe_gate}, 2);
      chk(fe_restart_pc == BASE + PCW'(L), "R7 pc", fe_restart_pc, BASE + PCW'(L));
    end
    do_flush();
  endtask

  initial begin
    int path[32]; int plen; int nf; int n;
    #0.5;
    chk(!fe_gate && !fe_restart && out_valid == 0, "R11 reset", {fe_gate, fe_restart}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    chk(!fe_gate && !fe_restart && out_valid == 0, "R11 after reset", out_valid, 0);

    // sweep every body length up to DEPTH+1 and every forward-branch mask
    for (int L = 1; L <= DEPTH + 1; L++)
      for (int m = 0; m < ((L >= 3) ? (1 << (L - 2)) : 1); m++)
        run_case(L, m);

    // R6: stray backward branch inside the capture pass
    capture(5, 0, 1, path, plen, nf);
    idle();
    chk(!fe_gate, "R6 stray backward", fe_gate, 0);
    do_flush();

    // R8: mispredict on the same cycle as the closing branch
    send(BASE + 16'd3, 1, 0, 1, BASE);
    for (int i = 0; i < 3; i++) send(BASE + PCW'(i), 0, 0, 0, '0);
    send(BASE + 16'd3, 1, 0, 1, BASE);
    mispredict = 1;
    idle();
    mispredict = 0;
    #0.5;
    chk(!fe_gate && !fe_restart, "R8 collision", {fe_gate, fe_restart}, 0);
    do_flush();

    // R10 then R8: stall during replay, then flush
    capture(4, 0, 0, path, plen, nf);
    idle();
    check_lanes(path, plen, 0, "R3 start");
    out_ready = 0;
    @(negedge clk); #0.5;
    check_lanes(path, plen, 0, "R10 hold");
    @(negedge clk); #0.5;
    check_lanes(path, plen, 0, "R10 hold");
    out_ready = 1;
    @(negedge clk); #0.5;
    check_lanes(path, plen, LANES, "R10 resume");
    do_flush();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule